// File: doc/BRIEF.md
# Video Controller CPU Port Decoder

This block is the processor-facing front end of a tile-based video controller. The processor reaches the controller through two byte-wide I/O ports. The data port moves bytes to and from video memory. The control port is a single 8-bit port that takes two successive writes. The first write is only held. The second write decides what happens. Either the held byte is loaded into one of eight configuration registers, or the two bytes together form a 14-bit video-memory pointer and set whether that pointer is used for reading or writing.

A small byte-phase latch tracks which half of a pair the next control write is. Any read or write of the data port clears the latch, and so does a read of the control port. The system uses this to recover from a half-written pair. Every data-port access moves the video-memory pointer forward by one. A data write produces a one-cycle write request toward memory, and a data read produces a one-cycle read request. A control-port read returns the status byte supplied from outside and sends a one-cycle strobe so that the status source can clear its flags.

Top module: `cpuport_ctl`

## Requirements
- R1: After reset, all eight registers read zero, the pointer is 0x0000, the mode flag is 0 (read), no request or strobe is active, and the next control write is treated as a first byte.
- R2: A first control write (port 0x99) changes no register, no pointer bit and no mode flag.
- R3: A second control write with bit 7 = 1 loads the held first byte into the register selected by bits 2:0 of that byte. Bits 6:3 have no effect. The register reads back (register n is regs_flat[8n+7:8n]) one cycle after the write.
- R4: A second control write with bit 7 = 0 sets the pointer to {bits 5:0 of that byte, held first byte} and sets the mode flag to bit 6 (1 = write, 0 = read). No register changes.
- R5: After a second control write is handled, the next control write is again treated as a first byte.
- R6: A read or a write of the data port (port 0x98) returns the latch to expect a first byte.
- R7: A read of the control port drives status_in onto cpu_rdata in the same cycle, pulses status_rd for one cycle after it, and returns the latch to expect a first byte.
- R8: Each data-port access advances the pointer by one, and 0x3FFF wraps to 0x0000.
- R9: A data-port write raises vram_wr_req for exactly one cycle after the access. vram_wr_addr holds the pointer value from before the increment and vram_wr_data holds the byte written.
- R10: A data-port read raises vram_rd_req for exactly one cycle after the access, with vram_rd_addr holding the pointer value from before the increment.
- R11: Reads and writes to any other port address change no register, no pointer and no byte phase, and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_port | input | 8 | I/O port address of the access |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access (takes precedence over cpu_rd) |
| status_in | input | 8 | Status byte returned on a control-port read |
| cpu_rdata | output | 8 | Read data: status_in during a control read, otherwise zero |
| regs_flat | output | 64 | Eight configuration registers, register n at bits 8n+7:8n |
| vram_addr | output | 14 | Current video-memory pointer |
| vram_wmode | output | 1 | Pointer mode: 1 write, 0 read |
| status_rd | output | 1 | One-cycle strobe after a control-port read |
| vram_wr_req | output | 1 | One-cycle memory write request |
| vram_wr_addr | output | 14 | Address of the write request |
| vram_wr_data | output | 8 | Data of the write request |
| vram_rd_req | output | 1 | One-cycle memory read request |
| vram_rd_addr | output | 14 | Address of the read request |

## Verification
A byte-phase latch that is stuck or out of step can be seen only on the next control write. The bench therefore follows every phase-clearing event with a new control pair and checks which byte ends up in a register. A wrong phase then shows up as a missing register load, or as a register loaded with the stale byte, one cycle after the second write. Pointer faults show up at vram_addr one cycle after each access, and in the request address. The pointer is driven to 0x3FFE first so that the wrap is exercised within two accesses.

// File: rtl/vdpc_pkg.sv
package vdpc_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_CNT   = 8;
    localparam int REG_IDX_W = $clog2(REG_CNT);
    localparam int ADDR_W    = 14;
    localparam int HI_BITS   = ADDR_W - BYTE_W;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTL_WR,
        ACC_CTL_RD,
        ACC_DAT_WR,
        ACC_DAT_RD
    } acc_e;

    typedef struct packed {
        logic                 reg_we;
        logic [REG_IDX_W-1:0] reg_idx;
        logic [BYTE_W-1:0]    reg_val;
        logic                 ptr_ld;
        logic [ADDR_W-1:0]    ptr_val;
        logic                 ptr_wmode;
    } cmd_t;

    // Write strobe wins when both strobes are present.
    function automatic acc_e classify(input logic [BYTE_W-1:0] port,
                                      input logic rd, input logic wr,
                                      input logic [BYTE_W-1:0] dport,
                                      input logic [BYTE_W-1:0] cport);
        acc_e a;
        a = ACC_NONE;
        if (wr) begin
            if (port == cport)      a = ACC_CTL_WR;
            else if (port == dport) a = ACC_DAT_WR;
        end else if (rd) begin
            if (port == cport)      a = ACC_CTL_RD;
            else if (port == dport) a = ACC_DAT_RD;
        end
        return a;
    endfunction

endpackage

// File: rtl/ctl_phase.sv
module ctl_phase
    import vdpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] wdata,
    output cmd_t              cmd,
    output logic              phase_hi
);

    logic              phase_q;
    logic [BYTE_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            low_q   <= '0;
        end else begin
            unique case (acc)
                ACC_CTL_WR: begin
                    if (!phase_q) low_q <= wdata;
                    phase_q <= ~phase_q;
                end
                ACC_CTL_RD, ACC_DAT_WR, ACC_DAT_RD: phase_q <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd = '0;
        if (acc == ACC_CTL_WR && phase_q) begin
            if (wdata[7]) begin
                cmd.reg_we  = 1'b1;
                cmd.reg_idx = wdata[REG_IDX_W-1:0];
                cmd.reg_val = low_q;
            end else begin
                cmd.ptr_ld    = 1'b1;
                cmd.ptr_val   = {wdata[HI_BITS-1:0], low_q};
                cmd.ptr_wmode = wdata[6];
            end
        end
    end

    assign phase_hi = phase_q;

    AST_PHASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_CTL_RD || acc == ACC_DAT_WR || acc == ACC_DAT_RD) |=> !phase_q); // R6
    AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_CTL_WR) |=> (phase_q != $past(phase_q))); // R5
    AST_PHASE_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_NONE) |=> $stable(phase_q)); // R11

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import vdpc_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [REG_IDX_W-1:0]               idx,
    input  logic [BYTE_W-1:0]                  val,
    output logic [REG_CNT-1:0][BYTE_W-1:0]     regs
);

    for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                   regs[i] <= '0;
            else if (we && idx == REG_IDX_W'(i))       regs[i] <= val;
        end
    end

    AST_REG_LOADS: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(idx)] == $past(val))); // R3

endmodule

// File: rtl/vram_ptr.sv
module vram_ptr
    import vdpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              ld_wmode,
    output logic [ADDR_W-1:0] addr,
    output logic              wmode,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr
);

    logic dat_acc;
    assign dat_acc = (acc == ACC_DAT_WR) || (acc == ACC_DAT_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            wmode   <= 1'b0;
            wr_req  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rd_req  <= 1'b0;
            rd_addr <= '0;
        end else begin
            wr_req <= (acc == ACC_DAT_WR);
            rd_req <= (acc == ACC_DAT_RD);
            if (acc == ACC_DAT_WR) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
            if (acc == ACC_DAT_RD) rd_addr <= addr;
            if (ld) begin
                addr  <= ld_val;
                wmode <= ld_wmode;
            end else if (dat_acc) begin
                addr <= addr + 1'b1;
            end
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        dat_acc |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R8
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld |=> (addr == $past(ld_val) && wmode == $past(ld_wmode))); // R4
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && rd_req)); // R10

endmodule

// File: rtl/cpuport_ctl.sv
module cpuport_ctl
    import vdpc_pkg::*;
#(
    parameter logic [7:0] DATA_PORT = 8'h98,
    parameter logic [7:0] CTRL_PORT = 8'h99
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cpu_port,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [7:0]  status_in,
    output logic [7:0]  cpu_rdata,
    output logic [63:0] regs_flat,
    output logic [13:0] vram_addr,
    output logic        vram_wmode,
    output logic        status_rd,
    output logic        vram_wr_req,
    output logic [13:0] vram_wr_addr,
    output logic [7:0]  vram_wr_data,
    output logic        vram_rd_req,
    output logic [13:0] vram_rd_addr
);

    acc_e                          acc;
    cmd_t                          cmd;
    logic                          phase_hi;
    logic [REG_CNT-1:0][BYTE_W-1:0] regs;

    assign acc = classify(cpu_port, cpu_rd, cpu_wr, DATA_PORT, CTRL_PORT);

    ctl_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .wdata    (cpu_wdata),
        .cmd      (cmd),
        .phase_hi (phase_hi)
    );

    cfg_regfile u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (cmd.reg_we),
        .idx  (cmd.reg_idx),
        .val  (cmd.reg_val),
        .regs (regs)
    );

    vram_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .wdata    (cpu_wdata),
        .ld       (cmd.ptr_ld),
        .ld_val   (cmd.ptr_val),
        .ld_wmode (cmd.ptr_wmode),
        .addr     (vram_addr),
        .wmode    (vram_wmode),
        .wr_req   (vram_wr_req),
        .wr_addr  (vram_wr_addr),
        .wr_data  (vram_wr_data),
        .rd_req   (vram_rd_req),
        .rd_addr  (vram_rd_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) status_rd <= 1'b0;
        else     status_rd <= (acc == ACC_CTL_RD);
    end

    assign cpu_rdata = (acc == ACC_CTL_RD) ? status_in : 8'h00;
    assign regs_flat = regs;

    AST_REGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cmd.reg_we |=> $stable(regs_flat)); // R2
    AST_FIRST_NO_PTR: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_CTL_WR && !phase_hi) |=> ($stable(vram_addr) && $stable(vram_wmode))); // R2
    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_CTL_RD) |=> status_rd); // R7

endmodule

// File: tb/sim_cpuport_ctl.sv
`timescale 1ns/1ps
module sim_cpuport_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  cpu_port, cpu_wdata, status_in, cpu_rdata;
    logic        cpu_rd, cpu_wr;
    logic [63:0] regs_flat;
    logic [13:0] vram_addr, vram_wr_addr, vram_rd_addr;
    logic        vram_wmode, status_rd, vram_wr_req, vram_rd_req;
    logic [7:0]  vram_wr_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [7:0] exp_regs [8];

    always #2 clk = ~clk;

    cpuport_ctl u0 (
        .clk(clk), .rst(rst), .cpu_port(cpu_port), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .status_in(status_in),
        .cpu_rdata(cpu_rdata), .regs_flat(regs_flat), .vram_addr(vram_addr),
        .vram_wmode(vram_wmode), .status_rd(status_rd),
        .vram_wr_req(vram_wr_req), .vram_wr_addr(vram_wr_addr),
        .vram_wr_data(vram_wr_data), .vram_rd_req(vram_rd_req),
        .vram_rd_addr(vram_rd_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < 8; i++)
            chk(req, {56'd0, regs_flat[8*i +: 8]}, {56'd0, exp_regs[i]});
    endtask

    // Drive on a falling edge. Return on the next falling edge, after one rising edge.
    task automatic io_wr(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        cpu_port = port; cpu_wdata = data; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic io_rd(input logic [7:0] port, output logic [7:0] rdata);
        @(negedge clk);
        cpu_port = port; cpu_rd = 1'b1;
        #1 rdata = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk_regs("R1 regs");
        chk("R1 addr", 64'(vram_addr), 64'h0);
        chk("R1 mode", 64'(vram_wmode), 64'h0);
        chk("R1 reqs", {61'd0, vram_wr_req, vram_rd_req, status_rd}, 64'h0);
        io_wr(8'h99, 8'h3C);
        io_wr(8'h99, 8'h80);
        exp_regs[0] = 8'h3C;
        chk_regs("R1 phase");
    endtask

    task automatic t_reg_write;
        io_wr(8'h99, 8'h5A);
        chk_regs("R2 regs");
        chk("R2 addr", 64'(vram_addr), 64'h0);
        chk("R2 mode", 64'(vram_wmode), 64'h0);
        io_wr(8'h99, 8'h83);
        exp_regs[3] = 8'h5A;
        chk_regs("R3 reg3");
        io_wr(8'h99, 8'h11);
        io_wr(8'h99, 8'hFD);
        exp_regs[5] = 8'h11;
        chk_regs("R3 bits6to3 ignored");
        chk("R3 addr untouched", 64'(vram_addr), 64'h0);
    endtask

    task automatic t_addr_setup;
        io_wr(8'h99, 8'h34);
        io_wr(8'h99, 8'h52);
        chk("R4 addr", 64'(vram_addr), 64'h1234);
        chk("R4 mode w", 64'(vram_wmode), 64'h1);
        chk_regs("R4 regs");
        io_wr(8'h99, 8'hCD);
        io_wr(8'h99, 8'h3F);
        chk("R4 addr2", 64'(vram_addr), 64'h3FCD);
        chk("R4 mode r", 64'(vram_wmode), 64'h0);
    endtask

    task automatic t_phase_return;
        io_wr(8'h99, 8'h77);
        io_wr(8'h99, 8'h81);
        exp_regs[1] = 8'h77;
        chk_regs("R5 new pair");
    endtask

    task automatic t_data_resets;
        logic [7:0] d;
        io_wr(8'h99, 8'h42);
        io_wr(8'h98, 8'h00);
        io_wr(8'h99, 8'h10);
        chk_regs("R6 after data wr");
        io_wr(8'h99, 8'h82);
        exp_regs[2] = 8'h10;
        chk_regs("R6 data wr");
        io_wr(8'h99, 8'h24);
        io_rd(8'h98, d);
        io_wr(8'h99, 8'h56);
        io_wr(8'h99, 8'h86);
        exp_regs[6] = 8'h56;
        chk_regs("R6 data rd");
    endtask

    task automatic t_ctl_read;
        logic [7:0] d;
        status_in = 8'hA5;
        io_wr(8'h99, 8'h99);
        io_rd(8'h99, d);
        chk("R7 rdata", 64'(d), 64'hA5);
        chk("R7 strobe", 64'(status_rd), 64'h1);
        @(negedge clk);
        chk("R7 strobe one cycle", 64'(status_rd), 64'h0);
        io_wr(8'h99, 8'h20);
        io_wr(8'h99, 8'h84);
        exp_regs[4] = 8'h20;
        chk_regs("R7 phase cleared");
    endtask

    task automatic t_incr_wrap;
        logic [7:0] d;
        io_wr(8'h99, 8'hFE);
        io_wr(8'h99, 8'h7F);
        chk("R4 addr 3ffe", 64'(vram_addr), 64'h3FFE);
        io_wr(8'h98, 8'hAB);
        chk("R9 req", 64'(vram_wr_req), 64'h1);
        chk("R9 addr", 64'(vram_wr_addr), 64'h3FFE);
        chk("R9 data", 64'(vram_wr_data), 64'hAB);
        chk("R8 step", 64'(vram_addr), 64'h3FFF);
        io_wr(8'h98, 8'hCD);
        chk("R9 addr2", 64'(vram_wr_addr), 64'h3FFF);
        chk("R9 data2", 64'(vram_wr_data), 64'hCD);
        chk("R8 wrap", 64'(vram_addr), 64'h0000);
        @(negedge clk);
        chk("R9 one cycle", 64'(vram_wr_req), 64'h0);
        io_rd(8'h98, d);
        chk("R10 req", 64'(vram_rd_req), 64'h1);
        chk("R10 addr", 64'(vram_rd_addr), 64'h0000);
        chk("R10 no wr", 64'(vram_wr_req), 64'h0);
        chk("R8 after rd", 64'(vram_addr), 64'h0001);
        @(negedge clk);
        chk("R10 one cycle", 64'(vram_rd_req), 64'h0);
    endtask

    task automatic t_other_ports;
        logic [7:0] d;
        io_wr(8'h99, 8'h66);
        io_wr(8'h97, 8'h8F);
        chk("R11 no wr req", 64'(vram_wr_req), 64'h0);
        io_rd(8'h9A, d);
        chk("R11 rdata", 64'(d), 64'h0);
        chk("R11 no rd req", 64'(vram_rd_req), 64'h0);
        chk("R11 addr", 64'(vram_addr), 64'h0001);
        chk_regs("R11 regs");
        io_wr(8'h99, 8'h87);
        exp_regs[7] = 8'h66;
        chk_regs("R11 phase kept");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_regs[i] = 8'h00;
        rst = 1'b1; cpu_port = 8'h00; cpu_wdata = 8'h00;
        cpu_rd = 1'b0; cpu_wr = 1'b0; status_in = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reg_write();
        t_addr_setup();
        t_phase_return();
        t_data_resets();
        t_ctl_read();
        t_incr_wrap();
        t_other_ports();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule